// File: doc/BRIEF.md
# Five-Stage In-Order Integer Core

This block is a 32-bit in-order processor core with five pipeline stages: fetch, decode, execute, memory access and writeback. It runs a small instruction set of eight operations: word load, word store, no-operation, register add, immediate add, signed 16-bit multiply, branch on equal and signed set-less-than. The core holds its own instruction store, its own data store and a 32-entry register file. Instruction and data storage are separate, so a fetch and a data access never compete for one port.

The core has no interlocks, no forwarding between stages and no stall logic. Software must space dependent instructions apart. A taken branch resolves in execute and discards the two younger instructions. The register file writes through to a read in the same cycle when `WB_BYPASS` is 1. With that setting, a consumer needs at least two unrelated instructions between itself and its producer.

A program port fills the instruction store while the core is held in reset. Two observation ports read any register and any data word, so a harness can compare architectural state after a run.

Top module: `pipe5_core`

## Requirements
- R1: Each instruction is 32 bits. Bits [31:26] hold the opcode, [25:21] the first source index (rs) and [20:16] the second source index (rt). R-form operations write the index in [15:11] (rd). Immediate operations take a signed 16-bit field from [15:0]. Opcodes are: add 000001, addi 000010, mul 000011, beq 010010, slt 010100, load 110000, store 110001, nop 000000.
- R2: A load writes rt with data word number ((rs + sext(imm)) >> 2). A store writes rt into that same word. A store never writes the register file.
- R3: add and addi produce the low 32 bits of the sum, with no overflow indication. add writes rd and addi writes rt.
- R4: mul treats the low 16 bits of rs and of rt as signed numbers. It writes their full 32-bit signed product to rd.
- R5: slt writes 1 to rd when rs is less than rt as signed 32-bit numbers, and writes 0 otherwise.
- R6: Register 0 always reads as zero, and any write to it is discarded.
- R7: When beq finds rs equal to rt, the next fetch address is (branch address + 4) + (sext(imm) << 2). The two instructions fetched after the branch are discarded without effect. A beq whose operands differ has no effect.
- R8: An opcode not listed in R1 behaves as nop. This holds even when its register fields are non-zero. The shift and funct fields [10:0] are ignored.
- R9: There are no interlocks. A result is visible to an instruction placed three slots after its producer, which leaves two instructions between them.
- R10: While reset is active, the fetch address is 0, every register reads 0 and the pipeline holds only nops.
- R11: Without a taken branch, the fetch address advances by 4 each cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| prog_we | input | 1 | Write strobe for the instruction store |
| prog_addr | input | 10 | Word index into the instruction store |
| prog_data | input | 32 | Instruction word to write |
| dbg_reg_sel | input | 5 | Register index to observe |
| dbg_reg_val | output | 32 | Current value of the selected register |
| dbg_mem_addr | input | 10 | Data word index to observe |
| dbg_mem_val | output | 32 | Current value of the selected data word |

## Verification
One program runs immediate values that are positive, negative and at the 16-bit limit. The mul case has operands with non-zero upper halves, which tells a low-half signed product apart from a full or unsigned one. slt is run with a negative operand on each side, which separates a signed compare from an unsigned one. Branches are tried taken forward, not taken, and taken backward. Loaded values are observed only after a store, writes to register 0 are attempted, and an unlisted opcode with live register fields is included. Placing each consumer exactly three slots after its producer shows whether results arrive at the intended pipeline distance.

// File: rtl/core_pkg.sv
`timescale 1ns/1ps
package core_pkg;

   localparam int ILEN = 32;

   localparam logic [5:0] OPC_NOP  = 6'b000000;
   localparam logic [5:0] OPC_ADD  = 6'b000001;
   localparam logic [5:0] OPC_ADDI = 6'b000010;
   localparam logic [5:0] OPC_MUL  = 6'b000011;
   localparam logic [5:0] OPC_BEQ  = 6'b010010;
   localparam logic [5:0] OPC_SLT  = 6'b010100;
   localparam logic [5:0] OPC_LD   = 6'b110000;
   localparam logic [5:0] OPC_ST   = 6'b110001;

   typedef enum logic [2:0] {
      K_NOP, K_ADD, K_ADDI, K_MUL, K_SLT, K_LD, K_ST, K_BEQ
   } kind_t;

   function automatic logic kind_writes_reg(kind_t k);
      return (k == K_ADD) || (k == K_ADDI) || (k == K_MUL) ||
             (k == K_SLT) || (k == K_LD);
   endfunction

endpackage

// File: rtl/core_regfile.sv
`timescale 1ns/1ps
module core_regfile #(
   parameter int XLEN      = 32,
   parameter int NREG      = 32,
   parameter bit WB_BYPASS = 1,
   localparam int AW       = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   input  logic [AW-1:0]   ra1,
   input  logic [AW-1:0]   ra2,
   input  logic [AW-1:0]   ra3,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2,
   output logic [XLEN-1:0] rd3
);

   logic [XLEN-1:0] regs [NREG];
   logic            wr_live;

   assign wr_live = we && (wa != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (wr_live) begin
         regs[wa] <= wd;
      end
   end

   generate
      if (WB_BYPASS) begin : g_wt
         assign rd1 = (ra1 == '0) ? '0 : (wr_live && wa == ra1) ? wd : regs[ra1];
         assign rd2 = (ra2 == '0) ? '0 : (wr_live && wa == ra2) ? wd : regs[ra2];
      end else begin : g_plain
         assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
         assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
      end
   endgenerate

   assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

endmodule

// File: rtl/core_decode.sv
`timescale 1ns/1ps
module core_decode
   import core_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [ILEN-1:0] instr,
   output kind_t           kind,
   output logic [4:0]      rs_idx,
   output logic [4:0]      rt_idx,
   output logic [4:0]      dst_idx,
   output logic [XLEN-1:0] imm_sx
);

   logic [10:0] unused_fields;
   assign unused_fields = instr[10:0];

   assign rs_idx = instr[25:21];
   assign rt_idx = instr[20:16];
   assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

   always_comb begin
      case (instr[31:26])
         OPC_ADD:  kind = K_ADD;
         OPC_ADDI: kind = K_ADDI;
         OPC_MUL:  kind = K_MUL;
         OPC_SLT:  kind = K_SLT;
         OPC_LD:   kind = K_LD;
         OPC_ST:   kind = K_ST;
         OPC_BEQ:  kind = K_BEQ;
         default:  kind = K_NOP;
      endcase
   end

   always_comb begin
      case (kind)
         K_ADD, K_MUL, K_SLT: dst_idx = instr[15:11];
         K_ADDI, K_LD:        dst_idx = instr[20:16];
         default:             dst_idx = '0;
      endcase
   end

endmodule

// File: rtl/core_alu.sv
`timescale 1ns/1ps
module core_alu
   import core_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int MUL_W = 16,
   localparam int PW   = 2 * MUL_W
) (
   input  kind_t           kind,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [XLEN-1:0] imm,
   output logic [XLEN-1:0] res
);

   logic [XLEN-1:0]  b_eff;
   logic signed [PW-1:0] prod;

   assign b_eff = (kind == K_ADDI || kind == K_LD || kind == K_ST) ? imm : opb;
   assign prod  = $signed(opa[MUL_W-1:0]) * $signed(opb[MUL_W-1:0]);

   always_comb begin
      case (kind)
         K_MUL:   res = {{(XLEN-PW){prod[PW-1]}}, prod};
         K_SLT:   res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
         default: res = opa + b_eff;
      endcase
   end

endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
   import core_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int IMEM_WORDS = 1024,
   parameter int DMEM_WORDS = 1024,
   parameter int NREG       = 32,
   parameter int MUL_W      = 16,
   parameter bit WB_BYPASS  = 1,
   localparam int IAW       = $clog2(IMEM_WORDS),
   localparam int DAW       = $clog2(DMEM_WORDS),
   localparam int RAW       = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            prog_we,
   input  logic [IAW-1:0]  prog_addr,
   input  logic [ILEN-1:0] prog_data,
   input  logic [RAW-1:0]  dbg_reg_sel,
   output logic [XLEN-1:0] dbg_reg_val,
   input  logic [DAW-1:0]  dbg_mem_addr,
   output logic [XLEN-1:0] dbg_mem_val
);

   generate
      if (NREG != 32) begin : g_bad_nreg
         $error("NREG must match the 5-bit register fields");
      end
      if (XLEN < 32 || IAW + 2 >= XLEN || DAW + 2 >= XLEN) begin : g_bad_xlen
         $error("XLEN too small for the address ranges");
      end
      if (2 * MUL_W > XLEN) begin : g_bad_mul
         $error("MUL_W product wider than XLEN");
      end
   endgenerate

   logic [ILEN-1:0] imem [IMEM_WORDS];
   logic [XLEN-1:0] dmem [DMEM_WORDS];

   // fetch
   logic [XLEN-1:0] pc;
   logic [ILEN-1:0] fetch_word;
   // IF/ID
   logic [ILEN-1:0] if_id_instr;
   logic [XLEN-1:0] if_id_pc4;
   // decode
   kind_t           dec_kind;
   logic [4:0]      dec_rs, dec_rt, dec_dst;
   logic [XLEN-1:0] dec_imm, rf_a, rf_b;
   // ID/EX
   kind_t           id_ex_kind;
   logic [XLEN-1:0] id_ex_a, id_ex_b, id_ex_imm, id_ex_pc4;
   logic [4:0]      id_ex_dst;
   // execute
   logic [XLEN-1:0] alu_res, br_target;
   logic            br_taken;
   // EX/MEM
   kind_t           ex_mem_kind;
   logic [XLEN-1:0] ex_mem_res, ex_mem_sdata;
   logic [4:0]      ex_mem_dst;
   logic [DAW-1:0]  d_idx;
   // MEM/WB
   logic            mem_wb_we;
   logic [4:0]      mem_wb_dst;
   logic [XLEN-1:0] mem_wb_val;

   logic unused_bits;
   assign unused_bits = ^{pc[1:0], pc[XLEN-1:IAW+2],
                          ex_mem_res[1:0], ex_mem_res[XLEN-1:DAW+2],
                          id_ex_imm[XLEN-1:XLEN-2]};

   // ---------------- fetch ----------------
   always_ff @(posedge clk) begin
      if (prog_we) imem[prog_addr] <= prog_data;
   end

   assign fetch_word = imem[pc[IAW+1:2]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc          <= '0;
         if_id_instr <= '0;
         if_id_pc4   <= '0;
      end else if (br_taken) begin
         pc          <= br_target;
         if_id_instr <= '0;
         if_id_pc4   <= '0;
      end else begin
         pc          <= pc + XLEN'(4);
         if_id_instr <= fetch_word;
         if_id_pc4   <= pc + XLEN'(4);
      end
   end

   // ---------------- decode ----------------
   core_decode #(.XLEN(XLEN)) u_dec (
      .instr   (if_id_instr),
      .kind    (dec_kind),
      .rs_idx  (dec_rs),
      .rt_idx  (dec_rt),
      .dst_idx (dec_dst),
      .imm_sx  (dec_imm)
   );

   core_regfile #(.XLEN(XLEN), .NREG(NREG), .WB_BYPASS(WB_BYPASS)) u_rf (
      .clk (clk),
      .rst_n (rst_n),
      .we  (mem_wb_we),
      .wa  (mem_wb_dst),
      .wd  (mem_wb_val),
      .ra1 (dec_rs),
      .ra2 (dec_rt),
      .ra3 (dbg_reg_sel),
      .rd1 (rf_a),
      .rd2 (rf_b),
      .rd3 (dbg_reg_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_ex_kind <= K_NOP;
         id_ex_a    <= '0;
         id_ex_b    <= '0;
         id_ex_imm  <= '0;
         id_ex_pc4  <= '0;
         id_ex_dst  <= '0;
      end else begin
         id_ex_kind <= br_taken ? K_NOP : dec_kind;
         id_ex_a    <= rf_a;
         id_ex_b    <= rf_b;
         id_ex_imm  <= dec_imm;
         id_ex_pc4  <= if_id_pc4;
         id_ex_dst  <= dec_dst;
      end
   end

   // ---------------- execute ----------------
   core_alu #(.XLEN(XLEN), .MUL_W(MUL_W)) u_alu (
      .kind (id_ex_kind),
      .opa  (id_ex_a),
      .opb  (id_ex_b),
      .imm  (id_ex_imm),
      .res  (alu_res)
   );

   assign br_taken  = (id_ex_kind == K_BEQ) && (id_ex_a == id_ex_b);
   assign br_target = id_ex_pc4 + {id_ex_imm[XLEN-3:0], 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_mem_kind  <= K_NOP;
         ex_mem_res   <= '0;
         ex_mem_sdata <= '0;
         ex_mem_dst   <= '0;
      end else begin
         ex_mem_kind  <= id_ex_kind;
         ex_mem_res   <= alu_res;
         ex_mem_sdata <= id_ex_b;
         ex_mem_dst   <= id_ex_dst;
      end
   end

   // ---------------- memory ----------------
   assign d_idx = ex_mem_res[DAW+1:2];

   always_ff @(posedge clk) begin
      if (ex_mem_kind == K_ST) dmem[d_idx] <= ex_mem_sdata;
   end

   assign dbg_mem_val = dmem[dbg_mem_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_wb_we  <= 1'b0;
         mem_wb_dst <= '0;
         mem_wb_val <= '0;
      end else begin
         mem_wb_we  <= kind_writes_reg(ex_mem_kind);
         mem_wb_dst <= ex_mem_dst;
         mem_wb_val <= (ex_mem_kind == K_LD) ? dmem[d_idx] : ex_mem_res;
      end
   end

endmodule

// File: rtl/pipe5_core_chk.sv
`timescale 1ns/1ps
module pipe5_core_chk
   import core_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XLEN-1:0] pc,
   input logic            br_taken,
   input logic [ILEN-1:0] if_id_instr,
   input kind_t           id_ex_kind,
   input kind_t           ex_mem_kind,
   input logic            mem_wb_we,
   input logic [4:0]      dbg_reg_sel,
   input logic [XLEN-1:0] dbg_reg_val
);

   assert_seq_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !br_taken |=> pc == $past(pc) + XLEN'(4));

   assert_flush_young_R7: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |=> (if_id_instr == '0) && (id_ex_kind == K_NOP));

   assert_store_no_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_mem_kind == K_ST) |=> !mem_wb_we);

   assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_reg_sel == 5'd0) |-> (dbg_reg_val == '0));

   assert_reset_pc_R10: assert property (@(posedge clk)
      $rose(rst_n) |-> (pc == '0) && (id_ex_kind == K_NOP));

endmodule

bind pipe5_core pipe5_core_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pc          (pc),
   .br_taken    (br_taken),
   .if_id_instr (if_id_instr),
   .id_ex_kind  (id_ex_kind),
   .ex_mem_kind (ex_mem_kind),
   .mem_wb_we   (mem_wb_we),
   .dbg_reg_sel (dbg_reg_sel),
   .dbg_reg_val (dbg_reg_val)
);

// File: tb/pipe5_core_test.sv
`timescale 1ns/1ps
module pipe5_core_test;

   function automatic logic [31:0] enc_r(logic [5:0] op, int rs, int rt, int rd);
      return {op, rs[4:0], rt[4:0], rd[4:0], 11'h5A5};
   endfunction

   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
      return {op, rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   localparam int NPROG = 24;
   // program: consumers sit exactly three slots after producers (R9)
   localparam logic [31:0] PROG [NPROG] = '{
      enc_i(6'b000010, 0, 1, 5),        // 0  addi r1 = 5
      enc_i(6'b000010, 0, 2, -3),       // 1  addi r2 = -3
      enc_i(6'b000010, 0, 3, 32767),    // 2  addi r3 = 0x7fff
      32'h0000_0000,                    // 3  nop
      enc_r(6'b000001, 1, 2, 4),        // 4  add r4 = r1+r2
      enc_r(6'b000011, 2, 3, 5),        // 5  mul r5 = r2*r3
      enc_r(6'b010100, 2, 1, 6),        // 6  slt r6 = r2<r1
      enc_r(6'b010100, 1, 2, 7),        // 7  slt r7 = r1<r2
      enc_r(6'b000001, 1, 1, 0),        // 8  add r0 (discarded)
      enc_i(6'b110001, 0, 5, 12),       // 9  store r5 -> word 3
      enc_r(6'b000001, 3, 3, 8),        // 10 add r8 = r3+r3
      enc_r(6'b111111, 1, 1, 9),        // 11 unlisted opcode
      32'h0000_0000,                    // 12 nop
      enc_i(6'b110000, 0, 10, 12),      // 13 load r10 <- word 3
      enc_i(6'b010010, 1, 1, 2),        // 14 beq taken -> 17
      enc_i(6'b000010, 0, 11, 1),       // 15 flushed
      enc_i(6'b000010, 0, 12, 1),       // 16 flushed
      enc_i(6'b000010, 0, 13, 7),       // 17 addi r13 = 7
      enc_i(6'b010010, 1, 2, 5),        // 18 beq not taken
      enc_i(6'b000010, 0, 14, 9),       // 19 addi r14 = 9
      enc_r(6'b000011, 8, 8, 15),       // 20 mul r15 = r8*r8 (low halves)
      enc_r(6'b010100, 5, 0, 16),       // 21 slt r16 = r5<0
      enc_i(6'b110001, 0, 14, 4),       // 22 store r14 -> word 1
      enc_i(6'b010010, 0, 0, -1)        // 23 beq self loop
   };

   localparam int NEXP = 19;
   // {requirement number, register index, expected value}
   localparam logic [44:0] EXP [NEXP] = '{
      {8'd6,  5'd0,  32'h0000_0000},   // R6
      {8'd3,  5'd1,  32'h0000_0005},   // R3
      {8'd3,  5'd2,  32'hFFFF_FFFD},   // R3
      {8'd1,  5'd3,  32'h0000_7FFF},   // R1
      {8'd9,  5'd4,  32'h0000_0002},   // R9
      {8'd4,  5'd5,  32'hFFFE_8003},   // R4
      {8'd5,  5'd6,  32'h0000_0001},   // R5
      {8'd5,  5'd7,  32'h0000_0000},   // R5
      {8'd3,  5'd8,  32'h0000_FFFE},   // R3
      {8'd8,  5'd9,  32'h0000_0000},   // R8
      {8'd2,  5'd10, 32'hFFFE_8003},   // R2
      {8'd7,  5'd11, 32'h0000_0000},   // R7
      {8'd7,  5'd12, 32'h0000_0000},   // R7
      {8'd7,  5'd13, 32'h0000_0007},   // R7
      {8'd7,  5'd14, 32'h0000_0009},   // R7
      {8'd4,  5'd15, 32'h0000_0004},   // R4
      {8'd5,  5'd16, 32'h0000_0001},   // R5
      {8'd11, 5'd17, 32'h0000_0000},   // R11
      {8'd8,  5'd31, 32'h0000_0000}    // R8
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        prog_we;
   logic [9:0]  prog_addr;
   logic [31:0] prog_data;
   logic [4:0]  dbg_reg_sel;
   logic [31:0] dbg_reg_val;
   logic [9:0]  dbg_mem_addr;
   logic [31:0] dbg_mem_val;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   pipe5_core uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .prog_we      (prog_we),
      .prog_addr    (prog_addr),
      .prog_data    (prog_data),
      .dbg_reg_sel  (dbg_reg_sel),
      .dbg_reg_val  (dbg_reg_val),
      .dbg_mem_addr (dbg_mem_addr),
      .dbg_mem_val  (dbg_mem_val)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic peek_reg(input int idx, output logic [31:0] v);
      @(negedge clk);
      dbg_reg_sel = idx[4:0];
      #1 v = dbg_reg_val;
   endtask

   task automatic peek_mem(input int idx, output logic [31:0] v);
      @(negedge clk);
      dbg_mem_addr = idx[9:0];
      #1 v = dbg_mem_val;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0;
      prog_we = 1'b0;
      prog_addr = '0;
      prog_data = '0;
      dbg_reg_sel = '0;
      dbg_mem_addr = '0;

      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         prog_we   = 1'b1;
         prog_addr = i[9:0];
         prog_data = (i < NPROG) ? PROG[i] : 32'h0;
      end
      @(negedge clk);
      prog_we = 1'b0;

      // R10: reset state of the register file
      peek_reg(1, v);  check("R10 r1 in reset", v, 32'h0);
      peek_reg(31, v); check("R10 r31 in reset", v, 32'h0);

      @(negedge clk);
      rst_n = 1'b1;
      repeat (80) @(negedge clk);

      for (int e = 0; e < NEXP; e++) begin
         peek_reg(int'(EXP[e][36:32]), v);
         check($sformatf("R%0d reg %0d", EXP[e][44:37], EXP[e][36:32]), v, EXP[e][31:0]);
      end

      // R2: stored words
      peek_mem(3, v); check("R2 mem word 3", v, 32'hFFFE_8003);
      peek_mem(1, v); check("R2 mem word 1", v, 32'h0000_0009);

      // R10: reset again clears registers, then the program reruns
      @(negedge clk);
      rst_n = 1'b0;
      peek_reg(5, v);  check("R10 r5 after reset", v, 32'h0);
      peek_reg(13, v); check("R10 r13 after reset", v, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (80) @(negedge clk);
      peek_reg(15, v); check("R4 rerun r15", v, 32'h0000_0004);
      peek_reg(12, v); check("R7 rerun r12 flushed", v, 32'h0);
      peek_reg(16, v); check("R5 rerun r16", v, 32'h0000_0001);

      finish_run();
   end

endmodule